// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block decides when a volatile SRAM array is copied into its nonvolatile shadow, and when the shadow is copied back. A store can start in three ways: a software request, an external strobe line pulled low, or the supply dropping below its threshold. A recall can start on a software request, or on its own once the supply comes up. The array copy itself lies outside the block. The sequencer raises a one-cycle start pulse with a direction bit, and it accepts a done pulse back. A clock-driven timer ends any copy that runs longer than its configured cycle budget.

A dirty flag records whether any SRAM write has been accepted since the last store or recall. When the external strobe triggers, the block stores only if the array is dirty. Whether the store runs or is skipped, the block then stays inhibited until the strobe line is released. During a store it starts by itself, the block pulls the shared strobe line low, so that other devices wired to the same line store together with it. While the block is inhibited, normal SRAM access is blocked, and requests that arrive during a copy are dropped.

The supply-level indication and the strobe line are asynchronous. Each passes through a synchronizer of `SYNC_STAGES` flops before the control logic uses it.

Top module: `nv_copy_seq`

## Requirements
- R1: After reset, access_inhibit is 1, copy_start is 0 and strobe_pull_low is 0, and the block waits for supply_ok.
- R2: When supply_ok becomes 1 after reset or after a power-down, a recall starts. copy_start is a one-cycle pulse seen SYNC_STAGES+1 cycles after the input change, with copy_to_nv = 0.
- R3: When the strobe line goes low while the block is idle, a store starts (copy_to_nv = 1) only if the array is dirty. Otherwise no copy_start is issued. The block does not pull the line low for a store that the strobe triggered.
- R4: After a strobe-triggered store ends, or after one is skipped, access_inhibit stays 1 while the line stays low. It returns to 0 SYNC_STAGES+1 cycles after the line goes high.
- R5: access_inhibit is 1 no later than SYNC_STAGES+1 cycles after the strobe line goes low while the block is idle.
- R6: A copy ends in the cycle after copy_done is sampled high. Without copy_done, it ends after STORE_CYCLES cycles for a store or RECALL_CYCLES cycles for a recall, counting the copy_start cycle.
- R7: A software store request in idle gives copy_start with copy_to_nv = 1 in the next cycle. strobe_pull_low is 1 for the whole store and 0 once the store ends. The block's own release of the line does not trigger a strobe store.
- R8: The dirty flag is set by a write (sram_wr) made while access_inhibit is 0. Writes made while inhibited are ignored. The flag is cleared when a store or a recall completes.
- R9: Software requests that arrive while a store or recall is active are ignored, and they have no effect after the copy ends.
- R10: A software recall request in idle gives copy_start with copy_to_nv = 0 in the next cycle.
- R11: When supply_ok goes to 0 while the block is idle, a store with strobe_pull_low = 1 starts SYNC_STAGES+1 cycles later. After it ends, access_inhibit stays 1 and no further copy starts until supply_ok returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above threshold (asynchronous) |
| sram_wr | input | 1 | An SRAM write is taking place this cycle |
| sw_store_req | input | 1 | Software store request pulse |
| sw_recall_req | input | 1 | Software recall request pulse |
| strobe_in | input | 1 | Sensed level of the shared strobe line, low = asserted |
| strobe_pull_low | output | 1 | 1 = pull the shared open-drain line low |
| access_inhibit | output | 1 | 1 = normal SRAM access is blocked |
| copy_start | output | 1 | One-cycle start pulse for the array copy |
| copy_to_nv | output | 1 | Copy direction: 1 = store to shadow, 0 = recall |
| copy_done | input | 1 | Copy engine has finished |

## Verification
Results of a software request are due in the next cycle. Anything caused by the supply or strobe inputs is due SYNC_STAGES+1 cycles after the input changes: the first two cycles go to the synchronizer and the third to the state register. The end of a copy shows one cycle after copy_done, or exactly the cycle budget after the copy_start cycle. The bench drives inputs on the falling edge and samples before it drives. It counts falling edges from each stimulus and checks at the count computed for that result. It also checks the cycle just before the due cycle, so a result that comes early fails as well as one that comes late.

// File: rtl/nv_seq_pkg.sv
package nv_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_RECALL = 3'd1,
    ST_IDLE   = 3'd2,
    ST_STORE  = 3'd3,
    ST_HOLD   = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    SRC_SW  = 2'd0,
    SRC_HW  = 2'd1,
    SRC_PWR = 2'd2
  } store_src_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // counter width able to hold the larger of two cycle budgets
  function automatic int unsigned budget_width(input int unsigned a, input int unsigned b);
    return $clog2(max_u(a, b) + 1);
  endfunction

  // a store drives the shared line only when this block started it
  function automatic logic drives_line(input store_src_e src);
    return src != SRC_HW;
  endfunction

  // where a finished store leaves the sequencer
  function automatic seq_state_e after_store(input store_src_e src);
    case (src)
      SRC_HW:  return ST_HOLD;
      SRC_PWR: return ST_OFF;
      default: return ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/nv_line_sync.sv
module nv_line_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_raw,
  input  logic strobe_raw,
  input  logic self_drive,
  output logic supply_s,
  output logic strobe_low_s,
  output logic strobe_evt
);
  localparam int unsigned GUARD = SYNC_STAGES + 1;
  localparam int unsigned GW    = $clog2(GUARD + 1);

  logic [SYNC_STAGES-1:0] sup_q;
  logic [SYNC_STAGES-1:0] stb_q;
  logic [GW-1:0]          guard_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sup_q <= '0;
          stb_q <= '1;
        end else begin
          sup_q <= supply_raw;
          stb_q <= strobe_raw;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sup_q <= '0;
          stb_q <= '1;
        end else begin
          sup_q <= {sup_q[SYNC_STAGES-2:0], supply_raw};
          stb_q <= {stb_q[SYNC_STAGES-2:0], strobe_raw};
        end
      end
    end
  endgenerate

  // masks the line while the block's own pull-low drains out of the chain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             guard_q <= '0;
    else if (self_drive)    guard_q <= GW'(GUARD);
    else if (guard_q != '0) guard_q <= guard_q - 1'b1;
  end

  assign supply_s     = sup_q[SYNC_STAGES-1];
  assign strobe_low_s = !stb_q[SYNC_STAGES-1];
  assign strobe_evt   = strobe_low_s && (guard_q == '0) && !self_drive;

endmodule

// File: rtl/nv_dur_timer.sv
module nv_dur_timer #(
  parameter int unsigned STORE_CYCLES  = 500000,
  parameter int unsigned RECALL_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic op_active,
  input  logic is_store,
  input  logic done_in,
  output logic first_cyc,
  output logic finish
);
  import nv_seq_pkg::*;
  localparam int unsigned CW = budget_width(STORE_CYCLES, RECALL_CYCLES);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;
  logic          expire;

  assign limit     = is_store ? CW'(STORE_CYCLES) : CW'(RECALL_CYCLES);
  assign expire    = op_active && (cnt_q == limit - 1'b1);
  assign first_cyc = op_active && (cnt_q == '0);
  assign finish    = op_active && (done_in || expire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!op_active || finish) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    op_active |-> (cnt_q < limit)); // R6

endmodule

// File: rtl/nv_dirty_track.sv
module nv_dirty_track (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ok,
  input  logic copy_end,
  output logic dirty
);
  logic dirty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dirty_q <= 1'b0;
    else if (copy_end) dirty_q <= 1'b0;
    else if (wr_ok)    dirty_q <= 1'b1;
  end

  assign dirty = dirty_q;

endmodule

// File: rtl/nv_copy_seq.sv
module nv_copy_seq #(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned STORE_CYCLES  = 500000,
  parameter int unsigned RECALL_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic sram_wr,
  input  logic sw_store_req,
  input  logic sw_recall_req,
  input  logic strobe_in,
  output logic strobe_pull_low,
  output logic access_inhibit,
  output logic copy_start,
  output logic copy_to_nv,
  input  logic copy_done
);
  import nv_seq_pkg::*;

  seq_state_e st_q, st_d;
  store_src_e src_q, src_d;

  logic supply_s, strobe_low_s, strobe_evt;
  logic op_active, is_store, first_cyc, op_finish;
  logic dirty, wr_ok, self_drive, idle_evt_skip;

  assign is_store   = (st_q == ST_STORE);
  assign op_active  = is_store || (st_q == ST_RECALL);
  assign self_drive = is_store && drives_line(src_q);

  nv_line_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n),
    .supply_raw(supply_ok), .strobe_raw(strobe_in), .self_drive(self_drive),
    .supply_s(supply_s), .strobe_low_s(strobe_low_s), .strobe_evt(strobe_evt)
  );

  nv_dur_timer #(.STORE_CYCLES(STORE_CYCLES), .RECALL_CYCLES(RECALL_CYCLES)) i_timer (
    .clk(clk), .rst_n(rst_n),
    .op_active(op_active), .is_store(is_store), .done_in(copy_done),
    .first_cyc(first_cyc), .finish(op_finish)
  );

  assign wr_ok = sram_wr && !access_inhibit;

  nv_dirty_track i_dirty (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .copy_end(op_finish), .dirty(dirty)
  );

  // strobe seen in idle with nothing to save
  assign idle_evt_skip = (st_q == ST_IDLE) && supply_s && strobe_evt && !dirty;

  always_comb begin
    st_d  = st_q;
    src_d = src_q;
    case (st_q)
      ST_OFF:    if (supply_s) st_d = ST_RECALL;
      ST_RECALL: if (op_finish) st_d = ST_IDLE;
      ST_STORE:  if (op_finish) st_d = after_store(src_q);
      ST_HOLD: begin
        if (!supply_s)          st_d = ST_OFF;
        else if (!strobe_low_s) st_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (!supply_s) begin
          st_d = ST_STORE; src_d = SRC_PWR;
        end else if (strobe_evt) begin
          st_d  = dirty ? ST_STORE : ST_HOLD;
          src_d = SRC_HW;
        end else if (sw_store_req) begin
          st_d = ST_STORE; src_d = SRC_SW;
        end else if (sw_recall_req) begin
          st_d = ST_RECALL;
        end
      end
      default: st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_OFF;
      src_q <= SRC_SW;
    end else begin
      st_q  <= st_d;
      src_q <= src_d;
    end
  end

  assign access_inhibit  = (st_q != ST_IDLE);
  assign copy_start      = first_cyc;
  assign copy_to_nv      = is_store;
  assign strobe_pull_low = self_drive;

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    copy_start |=> !copy_start); // R2

  AST_SKIP_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    idle_evt_skip |=> !copy_start); // R3

  AST_INHIBIT_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_IDLE) && strobe_evt) |=> access_inhibit); // R5

  AST_DIRTY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    op_finish |=> !dirty); // R8

  AST_PULL_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_pull_low) |-> copy_start); // R7

endmodule

// File: tb/test_nv_copy_seq.sv
module test_nv_copy_seq;
  localparam int SYNC = 2;
  localparam int SLIM = 40;
  localparam int RLIM = 24;
  localparam int LAT  = SYNC + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0, sram_wr = 1'b0, sw_store_req = 1'b0, sw_recall_req = 1'b0;
  logic ext_low = 1'b0, copy_done = 1'b0;
  logic strobe_in, strobe_pull_low, access_inhibit, copy_start, copy_to_nv;
  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  // shared open-drain line with weak pull-up
  assign strobe_in = !(ext_low || strobe_pull_low);

  nv_copy_seq #(.SYNC_STAGES(SYNC), .STORE_CYCLES(SLIM), .RECALL_CYCLES(RLIM)) i_nv_copy_seq (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .sram_wr(sram_wr),
    .sw_store_req(sw_store_req), .sw_recall_req(sw_recall_req), .strobe_in(strobe_in),
    .strobe_pull_low(strobe_pull_low), .access_inhibit(access_inhibit),
    .copy_start(copy_start), .copy_to_nv(copy_to_nv), .copy_done(copy_done)
  );

  function automatic logic exp_hw_store(input logic wrote);
    return wrote;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_done();
    copy_done = 1'b1; step(); copy_done = 1'b0;
  endtask

  task automatic do_write();
    sram_wr = 1'b1; step(); sram_wr = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    chk(access_inhibit && !copy_start && !strobe_pull_low, "R1 reset state",
        {access_inhibit, copy_start, strobe_pull_low}, 3'b100);
    rst_n = 1'b1;
    step(4);
    chk(access_inhibit && !copy_start, "R1 waits for supply", copy_start, 0);

    // R2 power-up recall, ended by timeout (R6)
    supply_ok = 1'b1;
    step(LAT - 1);
    chk(!copy_start, "R2 not early", copy_start, 0);
    step();
    chk(copy_start && !copy_to_nv, "R2 recall start", {copy_start, copy_to_nv}, 2'b10);
    step();
    chk(!copy_start, "R2 single pulse", copy_start, 0);
    step(RLIM - 2);
    chk(access_inhibit, "R6 recall still busy", access_inhibit, 1);
    step();
    chk(!access_inhibit, "R6 recall timeout end", access_inhibit, 0);

    // R3 clean strobe: skip, R5 inhibit latency, R4 hold
    step(2);
    ext_low = 1'b1;
    step(LAT - 1);
    chk(!access_inhibit, "R5 not early", access_inhibit, 0);
    step();
    chk(access_inhibit, "R5 inhibit on strobe", access_inhibit, 1);
    chk(!copy_start, "R3 clean skip", copy_start, 0);
    step(10);
    chk(access_inhibit && !copy_start, "R4 held while low", access_inhibit, 1);
    ext_low = 1'b0;
    step(LAT - 1);
    chk(access_inhibit, "R4 release not early", access_inhibit, 1);
    step();
    chk(!access_inhibit, "R4 release", access_inhibit, 0);

    // R3 dirty strobe store, R8
    do_write();
    ext_low = 1'b1;
    step(LAT);
    chk(copy_start && copy_to_nv && !strobe_pull_low, "R3 dirty store",
        {copy_start, copy_to_nv, strobe_pull_low}, 3'b110);
    pulse_done();
    chk(access_inhibit && !copy_to_nv, "R4 hold after store", access_inhibit, 1);
    ext_low = 1'b0;
    step(LAT);
    chk(!access_inhibit, "R4 idle after release", access_inhibit, 0);
    ext_low = 1'b1;
    step(LAT);
    chk(!copy_start, "R8 cleared by store", copy_start, 0);
    ext_low = 1'b0;
    step(LAT + 1);

    // R7 software store with pull-low, R9 request ignored
    sw_store_req = 1'b1; step(); sw_store_req = 1'b0;
    chk(copy_start && copy_to_nv && strobe_pull_low, "R7 sw store start",
        {copy_start, copy_to_nv, strobe_pull_low}, 3'b111);
    step(3);
    sw_recall_req = 1'b1; step(); sw_recall_req = 1'b0;
    chk(strobe_pull_low, "R7 pull held", strobe_pull_low, 1);
    pulse_done();
    chk(!strobe_pull_low && !access_inhibit, "R7 pull released",
        {strobe_pull_low, access_inhibit}, 0);
    for (int i = 0; i < 6; i++) begin
      chk(!copy_start && !access_inhibit, "R9 R7 no late start or false strobe",
          {copy_start, access_inhibit}, 0);
      step();
    end

    // R6 store timeout
    sw_store_req = 1'b1; step(); sw_store_req = 1'b0;
    chk(copy_start, "R6 store start", copy_start, 1);
    step(SLIM - 1);
    chk(access_inhibit, "R6 store busy", access_inhibit, 1);
    step();
    chk(!access_inhibit, "R6 store timeout end", access_inhibit, 0);
    step(LAT + 1);

    // R10 software recall clears dirty (R8)
    do_write();
    sw_recall_req = 1'b1; step(); sw_recall_req = 1'b0;
    chk(copy_start && !copy_to_nv, "R10 sw recall", {copy_start, copy_to_nv}, 2'b10);
    do_write();                       // R8 write while inhibited is ignored
    pulse_done();
    ext_low = 1'b1;
    step(LAT);
    chk(!copy_start && access_inhibit, "R8 recall clears, inhibited write ignored",
        copy_start, 0);
    ext_low = 1'b0;
    step(LAT + 1);

    // random strobe sequences
    for (int n = 0; n < 20; n++) begin
      logic wrote;
      wrote = 1'($urandom % 2);
      step(1 + int'($urandom % 5));
      if (wrote) do_write();
      ext_low = 1'b1;
      step(LAT);
      chk(copy_start == exp_hw_store(wrote), "R3 random strobe",
          copy_start, exp_hw_store(wrote));
      if (copy_start) begin
        step(int'($urandom % 4));
        pulse_done();
      end
      step(2);
      chk(access_inhibit, "R4 random hold", access_inhibit, 1);
      ext_low = 1'b0;
      step(LAT);
      chk(!access_inhibit, "R4 random release", access_inhibit, 0);
    end

    // R11 power-down store then recall on return
    supply_ok = 1'b0;
    step(LAT);
    chk(copy_start && copy_to_nv && strobe_pull_low, "R11 power store",
        {copy_start, copy_to_nv, strobe_pull_low}, 3'b111);
    pulse_done();
    step(8);
    chk(access_inhibit && !copy_start && !strobe_pull_low, "R11 off state",
        {access_inhibit, copy_start, strobe_pull_low}, 3'b100);
    supply_ok = 1'b1;
    step(LAT);
    chk(copy_start && !copy_to_nv, "R11 R2 recall on return",
        {copy_start, copy_to_nv}, 2'b10);
    pulse_done();
    chk(!access_inhibit, "R6 done ends recall", access_inhibit, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end

endmodule